// File: doc/BRIEF.md
# Reservation Station Array

This block holds the instructions waiting for one class of functional unit in an out-of-order core. An issuing instruction is written into a free station together with its reorder-buffer destination tag and two source operands. Each operand arrives either as a ready value or as the tag of the instruction that will produce it. A station can only accept an instruction when it is free, so a full array stalls issue.

Stations waiting on a tag watch the result broadcast bus. When a broadcast carries their tag, they take the value and clear the tag. A station whose two tags are clear is ready. Among the ready stations, the one with the lowest index is offered to the execution unit, and it is handed over when the unit accepts it. A station stays occupied after dispatch until the writeback-complete input names its destination tag.

Tag value 0 is reserved and means "no producer pending". It is never a valid producer or destination tag.

Top module: `rs_array`

## Requirements
- R1: After reset no station is occupied: `issueReady` is 1 and `dispValid` is 0.
- R2: An accepted issue (`issueValid` and `issueReady`) fills the lowest-index free station. `issueReady` is 0 while all stations are occupied, and an issue offered then changes nothing.
- R3: A source whose tag input is 0 is stored as the given value and counts as available.
- R4: A source with a nonzero tag waits. A later broadcast (`cdbValid`) whose `cdbTag` equals that tag loads `cdbData` as the operand and clears the tag.
- R5: A broadcast in the same cycle as the issue, whose tag matches a source of the issuing instruction, is captured by the new station.
- R6: `dispValid` is 1 only when some occupied, not-yet-dispatched station has both source tags clear.
- R7: When several stations are ready, the lowest-index one is presented. Its op, destination tag and two operand values appear on the dispatch outputs in the cycle after it became ready.
- R8: A station handed over (`dispValid` and `dispReady`) is never presented again.
- R9: A dispatched station whose destination tag equals `wbTag` while `wbValid` is 1 becomes free at the next clock edge.
- R10: A broadcast with tag 0, or with a tag that no station waits on, changes no operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Instruction offered for issue |
| issueOp | input | OpW | Operation code |
| issueDst | input | TagW | Reorder-buffer tag of the result (nonzero) |
| issueTagA | input | TagW | Producer tag of source A, 0 = value given |
| issueValA | input | DataW | Value of source A |
| issueTagB | input | TagW | Producer tag of source B, 0 = value given |
| issueValB | input | DataW | Value of source B |
| issueReady | output | 1 | A station is free |
| cdbValid | input | 1 | Broadcast present |
| cdbTag | input | TagW | Tag of broadcast result |
| cdbData | input | DataW | Broadcast result value |
| dispReady | input | 1 | Execution unit accepts an instruction |
| dispValid | output | 1 | A ready instruction is presented |
| dispOp | output | OpW | Operation of presented instruction |
| dispDst | output | TagW | Destination tag of presented instruction |
| dispValA | output | DataW | Operand A |
| dispValB | output | DataW | Operand B |
| wbValid | input | 1 | Result write-back completed |
| wbTag | input | TagW | Destination tag written back |

## Verification
Two events can meet on the same edge: a result broadcast and the issue of an instruction that waits on that very result. The bench provokes this directly by driving a matching `cdbTag` in the issue cycle. Random traffic with small tag ranges provokes it again many times. In each case the new station must be presented with the broadcast value in the next cycle and must never wait for a second broadcast. A second collision is a broadcast arriving while another station is being handed over. This is judged by comparing every dispatch against a bench model of the stations.

// File: rtl/rs_pkg.sv
package rs_pkg;
  parameter int unsigned RS_NUM = 4;

  // per-station strobes from control to datapath, one bit per station
  typedef struct packed {
    logic [RS_NUM-1:0] alloc;   // station written by issue this cycle
    logic [RS_NUM-1:0] sel;     // station presented for dispatch
    logic [RS_NUM-1:0] fire;    // presented station accepted
    logic [RS_NUM-1:0] freeVec; // station released by writeback
  } rsStrobes_t;
endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issueValid,
  input  logic              dispReady,
  input  logic              wbValid,
  input  logic [RS_NUM-1:0] opsReady,
  input  logic [RS_NUM-1:0] wbMatch,
  output logic [RS_NUM-1:0] busyVec,
  output logic              issueReady,
  output logic              dispValid,
  output rsStrobes_t        strobes
);
  logic [RS_NUM-1:0] busyQ, sentQ, freeMask, readyMask;

  assign freeMask   = ~busyQ;
  assign readyMask  = busyQ & ~sentQ & opsReady;
  assign issueReady = |freeMask;
  assign dispValid  = |readyMask;
  assign busyVec    = busyQ;

  always_comb begin
    strobes.alloc   = issueValid ? (freeMask & (~freeMask + 1'b1)) : '0;
    strobes.sel     = readyMask & (~readyMask + 1'b1);
    strobes.fire    = dispReady ? strobes.sel : '0;
    strobes.freeVec = wbValid ? (busyQ & sentQ & wbMatch) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyQ <= '0;
      sentQ <= '0;
    end else begin
      busyQ <= (busyQ & ~strobes.freeVec) | strobes.alloc;
      sentQ <= (sentQ | strobes.fire) & ~strobes.freeVec;
    end
  end

  // R2
  alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.alloc & busyQ) == '0);
  // R7
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobes.sel));
  // R8
  sent_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobes.fire) |=> ((sentQ & $past(strobes.fire)) == $past(strobes.fire)));
  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|strobes.freeVec) |=> ((busyQ & $past(strobes.freeVec)) == '0));
endmodule

// File: rtl/rs_datapath.sv
module rs_datapath
  import rs_pkg::*;
#(
  parameter int unsigned DataW = 16,
  parameter int unsigned TagW  = 4,
  parameter int unsigned OpW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rsStrobes_t        strobes,
  input  logic [RS_NUM-1:0] busyVec,
  input  logic [OpW-1:0]    issueOp,
  input  logic [TagW-1:0]   issueDst,
  input  logic [TagW-1:0]   issueTagA,
  input  logic [DataW-1:0]  issueValA,
  input  logic [TagW-1:0]   issueTagB,
  input  logic [DataW-1:0]  issueValB,
  input  logic              cdbValid,
  input  logic [TagW-1:0]   cdbTag,
  input  logic [DataW-1:0]  cdbData,
  input  logic [TagW-1:0]   wbTag,
  output logic [RS_NUM-1:0] opsReady,
  output logic [RS_NUM-1:0] wbMatch,
  output logic [OpW-1:0]    dispOp,
  output logic [TagW-1:0]   dispDst,
  output logic [DataW-1:0]  dispValA,
  output logic [DataW-1:0]  dispValB
);
  localparam logic [TagW-1:0] NoTag = '0;

  logic [OpW-1:0]   opQ   [RS_NUM];
  logic [TagW-1:0]  dstQ  [RS_NUM];
  logic [TagW-1:0]  tagAQ [RS_NUM];
  logic [TagW-1:0]  tagBQ [RS_NUM];
  logic [DataW-1:0] valAQ [RS_NUM];
  logic [DataW-1:0] valBQ [RS_NUM];

  logic cdbLive, hitA, hitB;
  assign cdbLive = cdbValid && (cdbTag != NoTag);
  assign hitA    = cdbLive && (issueTagA == cdbTag);
  assign hitB    = cdbLive && (issueTagB == cdbTag);

  for (genvar i = 0; i < RS_NUM; i++) begin : g_station
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        opQ[i]   <= '0;
        dstQ[i]  <= '0;
        tagAQ[i] <= NoTag;
        tagBQ[i] <= NoTag;
        valAQ[i] <= '0;
        valBQ[i] <= '0;
      end else if (strobes.alloc[i]) begin
        opQ[i]  <= issueOp;
        dstQ[i] <= issueDst;
        if (issueTagA == NoTag) begin
          tagAQ[i] <= NoTag;  valAQ[i] <= issueValA;
        end else if (hitA) begin
          tagAQ[i] <= NoTag;  valAQ[i] <= cdbData;
        end else begin
          tagAQ[i] <= issueTagA;  valAQ[i] <= '0;
        end
        if (issueTagB == NoTag) begin
          tagBQ[i] <= NoTag;  valBQ[i] <= issueValB;
        end else if (hitB) begin
          tagBQ[i] <= NoTag;  valBQ[i] <= cdbData;
        end else begin
          tagBQ[i] <= issueTagB;  valBQ[i] <= '0;
        end
      end else if (busyVec[i]) begin
        if (cdbLive && tagAQ[i] == cdbTag) begin
          tagAQ[i] <= NoTag;  valAQ[i] <= cdbData;
        end
        if (cdbLive && tagBQ[i] == cdbTag) begin
          tagBQ[i] <= NoTag;  valBQ[i] <= cdbData;
        end
      end
    end

    assign opsReady[i] = (tagAQ[i] == NoTag) && (tagBQ[i] == NoTag);
    assign wbMatch[i]  = (dstQ[i] == wbTag);

    // R4 R5
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cdbLive && (busyVec[i] || strobes.alloc[i])) |=>
        (!busyVec[i] || (tagAQ[i] != $past(cdbTag) && tagBQ[i] != $past(cdbTag))));
  end

  always_comb begin
    dispOp   = '0;
    dispDst  = '0;
    dispValA = '0;
    dispValB = '0;
    for (int i = 0; i < RS_NUM; i++) begin
      if (strobes.sel[i]) begin
        dispOp   = dispOp   | opQ[i];
        dispDst  = dispDst  | dstQ[i];
        dispValA = dispValA | valAQ[i];
        dispValB = dispValB | valBQ[i];
      end
    end
  end

  // R6
  ready_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.sel & ~opsReady) == '0);
endmodule

// File: rtl/rs_array.sv
module rs_array
  import rs_pkg::*;
#(
  parameter int unsigned DataW = 16,
  parameter int unsigned TagW  = 4,
  parameter int unsigned OpW   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issueValid,
  input  logic [OpW-1:0]   issueOp,
  input  logic [TagW-1:0]  issueDst,
  input  logic [TagW-1:0]  issueTagA,
  input  logic [DataW-1:0] issueValA,
  input  logic [TagW-1:0]  issueTagB,
  input  logic [DataW-1:0] issueValB,
  output logic             issueReady,
  input  logic             cdbValid,
  input  logic [TagW-1:0]  cdbTag,
  input  logic [DataW-1:0] cdbData,
  input  logic             dispReady,
  output logic             dispValid,
  output logic [OpW-1:0]   dispOp,
  output logic [TagW-1:0]  dispDst,
  output logic [DataW-1:0] dispValA,
  output logic [DataW-1:0] dispValB,
  input  logic             wbValid,
  input  logic [TagW-1:0]  wbTag
);
  rsStrobes_t        strobes;
  logic [RS_NUM-1:0] opsReady, wbMatch, busyVec;

  rs_ctrl u_ctrl (
    .clk, .rst_n, .issueValid, .dispReady, .wbValid,
    .opsReady, .wbMatch, .busyVec, .issueReady, .dispValid, .strobes
  );

  rs_datapath #(.DataW(DataW), .TagW(TagW), .OpW(OpW)) u_dp (
    .clk, .rst_n, .strobes, .busyVec,
    .issueOp, .issueDst, .issueTagA, .issueValA, .issueTagB, .issueValB,
    .cdbValid, .cdbTag, .cdbData, .wbTag,
    .opsReady, .wbMatch, .dispOp, .dispDst, .dispValA, .dispValB
  );
endmodule

// File: tb/tb_rs_array.sv
module tb_rs_array;
  localparam int N = 4;
  localparam int DW = 16, TW = 4, OW = 4;

  logic clk = 0, rst_n = 0;
  logic issueValid = 0, cdbValid = 0, dispReady = 0, wbValid = 0;
  logic [OW-1:0] issueOp = 0;
  logic [TW-1:0] issueDst = 0, issueTagA = 0, issueTagB = 0, cdbTag = 0, wbTag = 0;
  logic [DW-1:0] issueValA = 0, issueValB = 0, cdbData = 0;
  logic issueReady, dispValid;
  logic [OW-1:0] dispOp;
  logic [TW-1:0] dispDst;
  logic [DW-1:0] dispValA, dispValB;

  always #5 clk = ~clk;

  rs_array dut (.*);

  int total = 0, bad = 0;
  bit done = 0;

  bit mBusy[N], mSent[N];
  logic [OW-1:0] mOp[N];
  logic [TW-1:0] mDst[N], mTa[N], mTb[N];
  logic [DW-1:0] mVa[N], mVb[N];

  function automatic int lowestFree();
    for (int i = 0; i < N; i++) if (!mBusy[i]) return i;
    return -1;
  endfunction

  function automatic int lowestReady();
    for (int i = 0; i < N; i++)
      if (mBusy[i] && !mSent[i] && mTa[i] == 0 && mTb[i] == 0) return i;
    return -1;
  endfunction

  task automatic chk(string ph, string req, string sig, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s [%s] %s: actual=%0h expected=%0h", req, ph, sig, act, exp);
    end
  endtask

  // one clock: compare outputs, take the edge, advance the model
  task automatic cycle(string ph);
    int fr, rd;
    fr = lowestFree();
    rd = lowestReady();
    chk(ph, "R2", "issueReady", issueReady, fr >= 0);
    chk(ph, "R6", "dispValid", dispValid, rd >= 0);
    if (rd >= 0) begin
      chk(ph, "R7", "dispOp", dispOp, mOp[rd]);
      chk(ph, "R7", "dispDst", dispDst, mDst[rd]);
      chk(ph, "R7", "dispValA", dispValA, mVa[rd]);
      chk(ph, "R7", "dispValB", dispValB, mVb[rd]);
    end
    @(posedge clk);
    for (int i = 0; i < N; i++) begin
      if (mBusy[i]) begin
        if (cdbValid && cdbTag != 0 && mTa[i] == cdbTag) begin mTa[i] = 0; mVa[i] = cdbData; end
        if (cdbValid && cdbTag != 0 && mTb[i] == cdbTag) begin mTb[i] = 0; mVb[i] = cdbData; end
      end
      if (mBusy[i] && mSent[i] && wbValid && mDst[i] == wbTag) begin
        mBusy[i] = 0; mSent[i] = 0;
      end
    end
    if (rd >= 0 && dispReady) mSent[rd] = 1;
    if (issueValid && fr >= 0) begin
      mBusy[fr] = 1; mSent[fr] = 0; mOp[fr] = issueOp; mDst[fr] = issueDst;
      if (issueTagA == 0) begin mTa[fr] = 0; mVa[fr] = issueValA; end
      else if (cdbValid && cdbTag == issueTagA) begin mTa[fr] = 0; mVa[fr] = cdbData; end
      else begin mTa[fr] = issueTagA; mVa[fr] = 0; end
      if (issueTagB == 0) begin mTb[fr] = 0; mVb[fr] = issueValB; end
      else if (cdbValid && cdbTag == issueTagB) begin mTb[fr] = 0; mVb[fr] = cdbData; end
      else begin mTb[fr] = issueTagB; mVb[fr] = 0; end
    end
    @(negedge clk);
    issueValid = 0; cdbValid = 0; dispReady = 0; wbValid = 0;
  endtask

  task automatic iss(logic [3:0] op, logic [3:0] dst, logic [3:0] ta, logic [15:0] va,
                     logic [3:0] tb, logic [15:0] vb);
    issueValid = 1; issueOp = op; issueDst = dst;
    issueTagA = ta; issueValA = va; issueTagB = tb; issueValB = vb;
  endtask

  task automatic bcast(logic [3:0] t, logic [15:0] d);
    cdbValid = 1; cdbTag = t; cdbData = d;
  endtask

  task automatic wb(logic [3:0] t);
    wbValid = 1; wbTag = t;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) begin mBusy[i] = 0; mSent[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1 reset", "R1", "issueReady", issueReady, 1);
    chk("R1 reset", "R1", "dispValid", dispValid, 0);
    // R3 both sources given as values
    iss(1, 3, 0, 16'h0011, 0, 16'h0022); cycle("R3 issue values");
    dispReady = 1; cycle("R3 dispatch values");
    cycle("R8 no second offer");
    wb(3); cycle("R9 free by wb");
    chk("R9 freed", "R9", "issueReady", issueReady, 1);
    // R4 wait on a tag, then capture
    iss(2, 5, 2, 0, 0, 16'h0033); cycle("R4 issue waiting");
    dispReady = 1; cycle("R6 not ready yet");
    bcast(2, 16'h00AB); cycle("R4 broadcast");
    chk("R4 captured", "R4", "dispValA", dispValA, 16'h00AB);
    dispReady = 1; cycle("R4 dispatch captured");
    // R5 capture in the issue cycle
    iss(3, 6, 4, 0, 0, 16'h0044); bcast(4, 16'h005A); cycle("R5 same-cycle capture");
    chk("R5 presented", "R5", "dispValid", dispValid, 1);
    chk("R5 presented", "R5", "dispValA", dispValA, 16'h005A);
    dispReady = 1; cycle("R5 dispatch");
    // R10 tag 0 and unmatched tags do nothing
    iss(4, 7, 1, 0, 1, 0); cycle("R10 issue waiting");
    bcast(0, 16'hDEAD); cycle("R10 tag zero");
    bcast(9, 16'hBEEF); cycle("R10 unmatched tag");
    chk("R10 still waiting", "R10", "dispValid", dispValid, 0);
    // R2 fill and overfill
    iss(5, 8, 0, 16'h0055, 0, 16'h0066); cycle("R2 fill last");
    chk("R2 full", "R2", "issueReady", issueReady, 0);
    iss(6, 9, 0, 16'h0077, 0, 16'h0088); cycle("R2 issue while full ignored");
    dispReady = 1; cycle("R2 dispatch only ready one");
    chk("R2 nothing else", "R2", "dispValid", dispValid, 0);
    // R7 priority between two ready stations
    wb(5); cycle("R9 free slot0");
    wb(6); cycle("R9 free slot1");
    iss(7, 10, 0, 16'h0100, 0, 16'h0101); cycle("R7 issue slot0");
    iss(8, 11, 0, 16'h0200, 0, 16'h0201); cycle("R7 issue slot1");
    chk("R7 lowest first", "R7", "dispDst", dispDst, 10);
    dispReady = 1; cycle("R7 take lowest");
    chk("R7 next", "R7", "dispDst", dispDst, 11);
    dispReady = 1; cycle("R7 take next");
    bcast(1, 16'h0999); cycle("R4 release waiting");
    dispReady = 1; cycle("R8 drain");
    for (int t = 8; t < 12; t++) begin wb(t[3:0]); cycle("R9 cleanup"); end
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 2 == 0)
        iss($urandom % 16, 8 + $urandom % 8,
            ($urandom % 2) ? 4'($urandom % 8) : 4'd0, $urandom,
            ($urandom % 2) ? 4'($urandom % 8) : 4'd0, $urandom);
      if ($urandom % 2 == 0) bcast($urandom % 8, $urandom);
      dispReady = ($urandom % 3) != 0;
      if ($urandom % 3 == 0) wb(8 + $urandom % 8);
      cycle("R7 random");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule